// File: doc/BRIEF.md
# Pipeline Stage Stall and Replay Controller

This block is the status controller of a pipeline stage that sits between an upstream producer of instruction bundles and a downstream queue. Normally it passes each incoming bundle straight through in the same cycle. When the downstream side asks it to hold, either through a stall from the commit side or because the queue is full, the controller moves to a blocked state and keeps every bundle that still arrives in a small skid buffer. It raises a stall toward the upstream stage, so nothing is lost while that stall makes its way back.

Once both hold conditions clear, the controller replays the buffered bundles one per cycle in arrival order. The upstream stall stays raised until the buffer is empty, and then the stage returns to passing live traffic. A squash from the commit side, or the reorder-buffer squash indication, overrides everything else. It discards the buffered bundles and parks the stage in a squashing state until both indications drop. Three saturating counters record how many cycles the stage spends blocked, replaying and squashing. A sticky flag reports an arrival that found the buffer full.

States: Running, Blocked, Unblocking, Squashing. Transitions: Running to Blocked (hold), Blocked to Unblocking (hold clear), Unblocking to Blocked (hold again), Unblocking to Running (buffer drained), any of Running, Blocked or Unblocking to Squashing (squash), and Squashing to Running (both squash inputs low).

Top module: `stage_skid_ctrl`

## Requirements
- R1: After reset the state output reads Running (the state code is 0 for Running, 1 for Blocked, 2 for Unblocking and 3 for Squashing). At the same time the skid count is 0, the upstream stall is low, all three cycle counters are 0 and the overflow flag is low.
- R2: In Running, with no squash input and no hold (hold means the stall input or the queue-full input is high), the output valid and bundle equal the input valid and bundle in the same cycle. The replay marker and the upstream stall are low.
- R3: In Running, a hold without squash moves the state to Blocked on the next cycle. A valid bundle present in that cycle enters the skid buffer, and no output is produced in that cycle.
- R4: In Blocked the upstream stall is high and output valid is low in every cycle. Each valid input bundle is written into the skid buffer.
- R5: Blocked moves to Unblocking on the next cycle when the stall input and the queue-full input are both low and no squash input is high.
- R6: In Unblocking, with no hold and no squash, the oldest buffered bundle is presented with output valid and the replay marker high, one per cycle in arrival order, and the upstream stall stays high. The state returns to Running on the cycle after the buffer empties. A hold in Unblocking returns to Blocked without removing a bundle.
- R7: A high squash input or reorder-buffer squash input in Running, Blocked or Unblocking moves the state to Squashing on the next cycle and empties the skid buffer. Squash takes priority over hold, and the input bundle of that cycle is neither delivered nor stored.
- R8: Squashing lasts while either squash input is high and moves to Running on the cycle after both are low. In Squashing, output valid and the upstream stall are low.
- R9: The blocked, unblocking and squashing counters each increase by one for every cycle spent in their state and stop at their all-ones value.
- R10: A bundle that must be stored while the buffer holds SKID_DEPTH bundles and none leaves in that cycle is dropped and sets the overflow flag. Only reset clears the flag.
- R11: A store and a replay in the same Unblocking cycle both take effect. The skid count is unchanged, and the new bundle is replayed after those already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming bundle present |
| in_bundle | input | BUNDLE_W | Incoming bundle payload |
| dn_stall | input | 1 | Stall request from the commit side |
| cm_squash | input | 1 | Squash from the commit side |
| cm_rob_squash | input | 1 | Reorder-buffer squash in progress |
| q_full | input | 1 | Downstream queue full |
| up_stall | output | 1 | Stall toward the upstream stage |
| out_valid | output | 1 | Bundle to process this cycle |
| out_bundle | output | BUNDLE_W | Live or replayed bundle payload |
| out_from_skid | output | 1 | Output bundle comes from the skid buffer |
| state_o | output | 2 | Current state code |
| skid_count | output | $clog2(SKID_DEPTH+1) | Bundles held in the skid buffer |
| blk_cycles | output | CNT_W | Cycles spent in Blocked |
| unb_cycles | output | CNT_W | Cycles spent in Unblocking |
| sq_cycles | output | CNT_W | Cycles spent in Squashing |
| overflow_err | output | 1 | Sticky skid overflow flag |

## Verification
Two functions can fall in the same Unblocking cycle. One is the replay of the oldest buffered bundle. The other is the storing of a bundle that was already in flight when the upstream stall rose, or a squash that arrives during replay. The sweeps send valid bundles during the replay phase with the buffer at every fill level, including full, and inject squash at every step of a block-and-replay sequence. The bench judges each cycle's replayed payload, skid count and next state against an independent per-cycle queue model. That model takes the pop before the push, and flushing wins over both.

// File: rtl/skid_ctrl_pkg.sv
package skid_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_BLK = 2'd1,
        ST_UNB = 2'd2,
        ST_SQ  = 2'd3
    } stage_st_e;

    localparam int NUM_CTR = 3;

    // counter index -> the state whose residency it measures
    function automatic stage_st_e ctr_target(input int idx);
        stage_st_e r;
        case (idx)
            0:       r = ST_BLK;
            1:       r = ST_UNB;
            default: r = ST_SQ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/skid_fifo.sv
module skid_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          last,
    output logic          ovf
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          full, do_pop, do_push;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign last    = (count == CW'(1));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign ovf     = push && full && !do_pop;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/stage_fsm.sv
module stage_fsm
    import skid_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      hold,
    input  logic      sq_any,
    input  logic      skid_empty,
    input  logic      skid_last,
    output stage_st_e state,
    output logic      push,
    output logic      pop,
    output logic      flush,
    output logic      pass_live,
    output logic      up_stall
);

    stage_st_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sq_any)    state_d = ST_SQ;
                else if (hold) state_d = ST_BLK;
            end
            ST_BLK: begin
                if (sq_any)     state_d = ST_SQ;
                else if (!hold) state_d = ST_UNB;
            end
            ST_UNB: begin
                if (sq_any)    state_d = ST_SQ;
                else if (hold) state_d = ST_BLK;
                else if ((skid_empty || skid_last) && !in_valid)
                               state_d = ST_RUN;
            end
            ST_SQ: begin
                if (!sq_any) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        pass_live = 1'b0;
        up_stall  = 1'b0;
        flush     = sq_any && (state_q != ST_SQ);
        unique case (state_q)
            ST_RUN: begin
                pass_live = !sq_any && !hold;
                push      = !sq_any && hold && in_valid;
            end
            ST_BLK: begin
                up_stall = 1'b1;
                push     = !sq_any && in_valid;
            end
            ST_UNB: begin
                up_stall = 1'b1;
                push     = !sq_any && in_valid;
                pop      = !sq_any && !hold && !skid_empty;
            end
            ST_SQ: begin
                up_stall = 1'b0;
            end
            default: begin
                up_stall = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (en && ~&count)     count <= count + W'(1);
    end

endmodule

// File: rtl/stage_skid_ctrl.sv
module stage_skid_ctrl
    import skid_ctrl_pkg::*;
#(
    parameter int BUNDLE_W   = 16,
    parameter int SKID_DEPTH = 4,
    parameter int CNT_W      = 16,
    localparam int SCW       = $clog2(SKID_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BUNDLE_W-1:0] in_bundle,
    input  logic                dn_stall,
    input  logic                cm_squash,
    input  logic                cm_rob_squash,
    input  logic                q_full,
    output logic                up_stall,
    output logic                out_valid,
    output logic [BUNDLE_W-1:0] out_bundle,
    output logic                out_from_skid,
    output logic [1:0]          state_o,
    output logic [SCW-1:0]      skid_count,
    output logic [CNT_W-1:0]    blk_cycles,
    output logic [CNT_W-1:0]    unb_cycles,
    output logic [CNT_W-1:0]    sq_cycles,
    output logic                overflow_err
);

    stage_st_e           state;
    logic                hold, sq_any;
    logic                push, pop, flush, pass_live;
    logic                skid_empty, skid_last, ovf;
    logic [BUNDLE_W-1:0] head;
    logic [CNT_W-1:0]    ctr_val [NUM_CTR];

    assign hold   = dn_stall || q_full;
    assign sq_any = cm_squash || cm_rob_squash;

    stage_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .hold       (hold),
        .sq_any     (sq_any),
        .skid_empty (skid_empty),
        .skid_last  (skid_last),
        .state      (state),
        .push       (push),
        .pop        (pop),
        .flush      (flush),
        .pass_live  (pass_live),
        .up_stall   (up_stall)
    );

    skid_fifo #(.W(BUNDLE_W), .DEPTH(SKID_DEPTH)) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (in_bundle),
        .pop       (pop),
        .head      (head),
        .count     (skid_count),
        .empty     (skid_empty),
        .last      (skid_last),
        .ovf       (ovf)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (state == ctr_target(g)),
            .count (ctr_val[g])
        );
    end

    assign blk_cycles = ctr_val[0];
    assign unb_cycles = ctr_val[1];
    assign sq_cycles  = ctr_val[2];

    always_ff @(posedge clk) begin
        if (!rst_n)   overflow_err <= 1'b0;
        else if (ovf) overflow_err <= 1'b1;
    end

    always_comb begin
        out_valid     = 1'b0;
        out_bundle    = '0;
        out_from_skid = pop;
        if (pass_live) begin
            out_valid  = in_valid;
            out_bundle = in_bundle;
        end else if (pop) begin
            out_valid  = 1'b1;
            out_bundle = head;
        end
    end

    assign state_o = state;

endmodule

// File: rtl/stage_skid_ctrl_chk.sv
module stage_skid_ctrl_chk #(
    parameter int SCW   = 3,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dn_stall,
    input logic             q_full,
    input logic             cm_squash,
    input logic             cm_rob_squash,
    input logic             up_stall,
    input logic             out_valid,
    input logic             out_from_skid,
    input logic [1:0]       state_o,
    input logic [SCW-1:0]   skid_count,
    input logic [CNT_W-1:0] blk_cycles,
    input logic             overflow_err
);

    // R4
    blocked_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |-> (up_stall && !out_valid));

    // R3
    run_to_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && !cm_squash && !cm_rob_squash && (dn_stall || q_full))
        |=> (state_o == 2'd1));

    // R6
    replay_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && out_valid) |-> (out_from_skid && up_stall));

    // R7
    squash_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_squash || cm_rob_squash) |=> (state_o == 2'd3 && skid_count == '0));

    // R8
    squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) |-> (!up_stall && !out_valid));

    // R9
    blk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && ~&blk_cycles) |=> (blk_cycles == $past(blk_cycles) + CNT_W'(1)));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

endmodule

bind stage_skid_ctrl stage_skid_ctrl_chk #(.SCW(SCW), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dn_stall      (dn_stall),
    .q_full        (q_full),
    .cm_squash     (cm_squash),
    .cm_rob_squash (cm_rob_squash),
    .up_stall      (up_stall),
    .out_valid     (out_valid),
    .out_from_skid (out_from_skid),
    .state_o       (state_o),
    .skid_count    (skid_count),
    .blk_cycles    (blk_cycles),
    .overflow_err  (overflow_err)
);

// File: tb/stage_skid_ctrl_bench.sv
module stage_skid_ctrl_bench;

    localparam int BW  = 8;
    localparam int DP  = 4;
    localparam int CW  = 4;
    localparam int SCW = $clog2(DP + 1);
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [BW-1:0] in_bundle = '0;
    logic          dn_stall = 1'b0, cm_squash = 1'b0, cm_rob_squash = 1'b0, q_full = 1'b0;
    logic          up_stall, out_valid, out_from_skid, overflow_err;
    logic [BW-1:0] out_bundle;
    logic [1:0]    state_o;
    logic [SCW-1:0] skid_count;
    logic [CW-1:0] blk_cycles, unb_cycles, sq_cycles;

    always #2.5 clk = ~clk;

    stage_skid_ctrl #(.BUNDLE_W(BW), .SKID_DEPTH(DP), .CNT_W(CW)) u_stage_skid_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bundle(in_bundle),
        .dn_stall(dn_stall), .cm_squash(cm_squash), .cm_rob_squash(cm_rob_squash),
        .q_full(q_full), .up_stall(up_stall), .out_valid(out_valid),
        .out_bundle(out_bundle), .out_from_skid(out_from_skid), .state_o(state_o),
        .skid_count(skid_count), .blk_cycles(blk_cycles), .unb_cycles(unb_cycles),
        .sq_cycles(sq_cycles), .overflow_err(overflow_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    int            m_st;
    logic [BW-1:0] mq [DP];
    int            mc;
    bit            m_err;
    int            mb, mu, ms;
    logic [BW-1:0] seq_data = 8'h01;
    logic [15:0]   lfsr = 16'hACE1;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string st_tag(input int s);
        case (s)
            0: return "R8";
            1: return "R3";
            2: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic model_reset();
        m_st = 0; mc = 0; m_err = 0; mb = 0; mu = 0; ms = 0;
    endtask

    // one clock cycle: drive, compare, advance the model
    task automatic cyc(input bit iv, input bit ds, input bit sq, input bit rs, input bit qf);
        bit sqa, hold, live, epop, epush, ev;
        logic [BW-1:0] eb, ib;
        @(negedge clk);
        ib = seq_data;
        seq_data = seq_data + 8'd1;
        in_valid = iv; in_bundle = ib; dn_stall = ds; cm_squash = sq;
        cm_rob_squash = rs; q_full = qf;
        #1;
        sqa  = sq || rs;
        hold = ds || qf;
        live = (m_st == 0) && !sqa && !hold;
        epop = (m_st == 2) && !sqa && !hold && (mc > 0);
        ev   = live ? iv : epop;
        eb   = live ? ib : mq[0];
        chk(st_tag(m_st), "state", int'(state_o), m_st);
        chk("R4", "up_stall", int'(up_stall), int'(m_st == 1 || m_st == 2));
        chk(live ? "R2" : "R6", "out_valid", int'(out_valid), int'(ev));
        chk("R6", "out_from_skid", int'(out_from_skid), int'(epop));
        if (ev) chk(live ? "R2" : "R11", "out_bundle", int'(out_bundle), int'(eb));
        chk("R11", "skid_count", int'(skid_count), mc);
        chk("R10", "overflow_err", int'(overflow_err), int'(m_err));
        chk("R9", "blk_cycles", int'(blk_cycles), mb);
        chk("R9", "unb_cycles", int'(unb_cycles), mu);
        chk("R9", "sq_cycles", int'(sq_cycles), ms);
        // advance
        if (m_st == 1 && mb < CMAX) mb++;
        if (m_st == 2 && mu < CMAX) mu++;
        if (m_st == 3 && ms < CMAX) ms++;
        epush = !sqa && iv && ((m_st == 1) || (m_st == 2) || (m_st == 0 && hold));
        if (epop) begin
            for (int i = 0; i < DP - 1; i++) mq[i] = mq[i + 1];
            mc--;
        end
        if (epush) begin
            if (mc < DP) begin mq[mc] = ib; mc++; end
            else m_err = 1;
        end
        case (m_st)
            0: if (sqa) m_st = 3; else if (hold) m_st = 1;
            1: if (sqa) m_st = 3; else if (!hold) m_st = 2;
            2: if (sqa) m_st = 3; else if (hold) m_st = 1; else if (mc == 0) m_st = 0;
            default: if (!sqa) m_st = 0;
        endcase
        if (sqa && m_st == 3) mc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 0; dn_stall = 0; cm_squash = 0; cm_rob_squash = 0; q_full = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        // R1
        chk("R1", "reset state", int'(state_o), 0);
        chk("R1", "reset count", int'(skid_count), 0);
        chk("R1", "reset stall", int'(up_stall), 0);
        chk("R1", "reset counters", int'(blk_cycles) + int'(unb_cycles) + int'(sq_cycles), 0);
        chk("R1", "reset err", int'(overflow_err), 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        do_reset();
        // R2: live pass-through, valid and idle mixes
        for (int i = 0; i < 8; i++) cyc(i[0], 1'b0, 1'b0, 1'b0, 1'b0);

        // R3 R4 R5 R6 R10: fill sweep 0..DP+2 bundles, stall or queue-full as the cause
        for (int n = 0; n <= DP + 2; n++) begin
            for (int useq = 0; useq < 2; useq++) begin
                cyc(n > 0, !useq[0], 1'b0, 1'b0, useq[0]);
                for (int i = 1; i < n; i++) cyc(1'b1, !useq[0], 1'b0, 1'b0, useq[0]);
                cyc(1'b0, !useq[0], 1'b0, 1'b0, useq[0]);
                drain();
            end
        end

        // R11: in-flight arrivals during replay at each fill level
        for (int n = 1; n <= DP; n++) begin
            for (int p = 1; p <= 3; p++) begin
                cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
                for (int i = 1; i < n; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
                for (int i = 0; i < p; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
                // re-stall mid replay, then release (R6)
                cyc(1'b0, 1'b0, 1'b0, 1'b0, p == 2);
                drain();
            end
        end

        // R7 R8: squash injected at every step of a block/replay sequence
        for (int ph = 0; ph < 9; ph++) begin
            for (int k = 0; k < 9; k++) begin
                bit s = (k == ph) || (k == ph + 1);
                bit isrob = ph[0];
                if (k < 3)      cyc(1'b1, 1'b1, s && !isrob, s && isrob, 1'b0);
                else if (k < 5) cyc(1'b1, 1'b0, s && !isrob, s && isrob, 1'b0);
                else            cyc(1'b0, 1'b0, s && !isrob, s && isrob, 1'b0);
            end
            drain();
        end
        // overlapping squash sources keep Squashing (R8)
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        drain();

        // R9: saturation of all three counters
        for (int i = 0; i < CMAX + 4; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < CMAX + 4; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int r = 0; r < 20; r++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drain();

        // mixed pseudo-random traffic
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], lfsr[3] & lfsr[1], lfsr[7] & lfsr[5] & lfsr[2],
                lfsr[9] & lfsr[11] & lfsr[4], lfsr[6] & lfsr[8]);
        end

        // R10: flag is cleared by reset only
        for (int i = 0; i < DP + 2; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        drain();
        chk("R10", "flag held after drain", int'(overflow_err), 1);
        do_reset();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule